// File: doc/BRIEF.md
# TDM D-Channel Framed Serial Transmitter

This block takes bytes written from a parallel processor port, holds them in a 32-entry byte FIFO, and shifts them out one bit at a time into a single channel timeslot of a time-division-multiplexed serial stream. Each transmitted unit is wrapped in start/parity/stop framing of the asynchronous kind. The start bit is 0, the stop bit is 1, and the line rests at 1 between units. Data goes least significant bit first. An input marks the stream's frame boundary. A second input marks the clock cycles that are bit positions of the selected timeslot. A rate field caps how many of those positions are used in each TDM frame: 1, 2 or 8.

There are two operating modes. In message mode, software first writes a message length in bytes. The whole message is then sent as one frame: one start bit, all of its data bits, an optional parity bit and one stop bit. The interrupt rises once the stop bit has gone out. If the FIFO runs dry inside a message, the block flags an underrun and closes the frame at once with a stop bit. In FIFO mode, each byte gets its own start, parity and stop bits, or no framing at all when the unframed option is set. The interrupt then follows the FIFO fill level against a programmable threshold.

Top module: `dchan_tdm_tx`

## Requirements
- R1: The FIFO holds 32 bytes. A write while it holds 32 bytes is dropped and leaves the queued data unchanged.
- R2: Message mode (mode_fifo=0), once armed by a nonzero length write, sends a 0 start bit. It then sends every byte of the message LSB first with no gaps, the parity bit when par_en=1, and a 1 stop bit.
- R3: In message mode, irq is 0 after reset and after a length write. It becomes 1 when the stop bit of a message completed without underrun has been sent, and it stays 1 until the next length write.
- R4: In FIFO mode (mode_fifo=1, unframed=0), each byte is sent as 0, its 8 bits LSB first, the parity bit when par_en=1, then 1. The next queued byte starts in the slot right after the stop bit.
- R5: In FIFO mode, irq is 1 exactly while the FIFO occupancy is at or below irq_thresh. It drops as soon as a write lifts the occupancy above irq_thresh.
- R6: In FIFO mode with unframed=1, queued bytes are sent back to back as bare data bits, LSB first, with no start, parity or stop bits.
- R7: rate_sel sets the number of bits sent per TDM frame: 0 gives 1 bit, 1 gives 2 bits, and 2 or 3 gives 8 bits. Only timeslot positions (ts_en=1) count, and the count restarts at frame_sync.
- R8: The parity bit makes the count of ones over the parity-covered data plus the parity bit even when par_odd=0, and odd when par_odd=1. In message mode it covers the whole message; in FIFO mode it covers one byte.
- R9: If the FIFO is empty when a message-mode frame needs its next byte, underrun goes to 1, the next bit sent is a 1 stop bit with no parity, and irq stays 0. A length write clears underrun.
- R10: tx_slot is 1 for one cycle after each used timeslot position, and tx_bit then holds the bit sent there. After reset, and whenever no unit is in progress, the bit sent is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; ts_en marks which cycles are bit positions |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one byte into the FIFO |
| wr_data | input | 8 | Byte to write |
| len_wr | input | 1 | Load message length and arm message mode |
| len_val | input | 6 | Message length in bytes, 1 to 32; 0 is ignored |
| mode_fifo | input | 1 | 0 message mode, 1 FIFO mode |
| unframed | input | 1 | FIFO mode only: send bytes without framing bits |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| rate_sel | input | 2 | Bits per TDM frame: 0 one, 1 two, 2/3 eight |
| irq_thresh | input | 6 | FIFO-mode interrupt threshold, occupancy at or below |
| frame_sync | input | 1 | Start of a TDM frame |
| ts_en | input | 1 | Current cycle is a bit position of the channel timeslot |
| tx_bit | output | 1 | Serial bit sent in the last used position |
| tx_slot | output | 1 | tx_bit has just been updated for a used position |
| irq | output | 1 | Interrupt, meaning set by mode |
| underrun | output | 1 | FIFO ran dry inside a message |

## Verification
Message mode is tried with two-byte, one-byte and underrunning messages. These separate parity over the whole message from parity per byte, and separate a normal close from a forced stop. FIFO mode is driven both framed and unframed. The framed stream shows that framing repeats per byte, and the bare bit stream shows that no framing bits leak in. Running one message at each rate shows that the per-frame cap counts only timeslot positions. A 33-byte write burst drained unframed reveals whether the overflow byte slipped in. A nine-byte fill followed by one pop and one refill moves occupancy across the interrupt threshold in both directions.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } fr_state_t;

    localparam logic [1:0] RATE_ONE = 2'd0;
    localparam logic [1:0] RATE_TWO = 2'd1;
endpackage

// File: rtl/dtx_fifo.sv
module dtx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok, full;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[s_q.rd];
    assign count   = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (push_ok) s_d.wr = s_q.wr + 1'b1;
        if (pop_ok)  s_d.rd = s_q.rd + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr] <= push_data;
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (s_q.cnt == CW'(DEPTH)));

    // R1
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dtx_slot_gate.sv
module dtx_slot_gate
    import dtx_pkg::*;
#(
    parameter int MAX_BITS = 8,
    localparam int NW      = $clog2(MAX_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    input  logic       ts_en,
    input  logic [1:0] rate_sel,
    output logic       step
);
    logic [NW-1:0] used_q, used_d, lim;

    always_comb begin
        case (rate_sel)
            RATE_ONE: lim = NW'(1);
            RATE_TWO: lim = NW'(2);
            default:  lim = NW'(MAX_BITS);
        endcase
        step   = ts_en && (frame_sync || (used_q < lim));
        used_d = used_q;
        if (frame_sync)  used_d = step ? NW'(1) : '0;
        else if (step)   used_d = used_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

    // R7
    rate_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !frame_sync) |=> (used_q <= lim));
endmodule

// File: rtl/dtx_framer.sv
module dtx_framer
    import dtx_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = 6,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          mode_fifo,
    input  logic          unframed,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          len_wr,
    input  logic [LW-1:0] len_val,
    input  logic          fifo_empty,
    input  logic [W-1:0]  head,
    output logic          pop,
    output logic          tx_bit,
    output logic          tx_slot,
    output logic          done,
    output logic          err
);
    typedef struct packed {
        fr_state_t     state;
        logic [W-1:0]  sh;
        logic [IW-1:0] idx;
        logic [LW-1:0] rem;
        logic          par;
        logic          armed;
        logic          done;
        logic          err;
        logic          tx_bit;
        logic          tx_slot;
    } fr_st_t;

    localparam fr_st_t RESET_ST = '{state: ST_IDLE, sh: '0, idx: '0, rem: '0,
        par: 1'b0, armed: 1'b0, done: 1'b0, err: 1'b0, tx_bit: 1'b1, tx_slot: 1'b0};

    fr_st_t q, d;

    always_comb begin
        d         = q;
        pop       = 1'b0;
        d.tx_slot = step;
        if (len_wr && (len_val != '0)) begin
            d.armed = 1'b1;
            d.rem   = len_val;
            d.done  = 1'b0;
            d.err   = 1'b0;
        end
        if (step) begin
            case (q.state)
                ST_IDLE: begin
                    d.tx_bit = 1'b1;
                    if (!fifo_empty && (mode_fifo || q.armed)) begin
                        pop     = 1'b1;
                        d.par   = 1'b0;
                        d.state = ST_DATA;
                        if (!mode_fifo) d.armed = 1'b0;
                        if (mode_fifo && unframed) begin
                            d.tx_bit = head[0];
                            d.sh     = head >> 1;
                            d.idx    = IW'(1);
                        end else begin
                            d.tx_bit = 1'b0;
                            d.sh     = head;
                            d.idx    = '0;
                        end
                    end
                end
                ST_DATA: begin
                    d.tx_bit = q.sh[0];
                    d.sh     = q.sh >> 1;
                    d.par    = q.par ^ q.sh[0];
                    d.idx    = q.idx + 1'b1;
                    if (q.idx == IW'(W - 1)) begin
                        if (!mode_fifo) begin
                            d.rem = q.rem - 1'b1;
                            if (q.rem == LW'(1)) begin
                                d.state = par_en ? ST_PAR : ST_STOP;
                            end else if (!fifo_empty) begin
                                pop   = 1'b1;
                                d.sh  = head;
                                d.idx = '0;
                            end else begin
                                d.err   = 1'b1;
                                d.state = ST_STOP;
                            end
                        end else if (unframed) begin
                            if (!fifo_empty) begin
                                pop   = 1'b1;
                                d.sh  = head;
                                d.idx = '0;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else begin
                            d.state = par_en ? ST_PAR : ST_STOP;
                        end
                    end
                end
                ST_PAR: begin
                    d.tx_bit = q.par ^ par_odd;
                    d.state  = ST_STOP;
                end
                default: begin
                    d.tx_bit = 1'b1;
                    d.state  = ST_IDLE;
                    if (!mode_fifo && !q.err) d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_ST;
        else        q <= d;
    end

    assign tx_bit  = q.tx_bit;
    assign tx_slot = q.tx_slot;
    assign done    = q.done;
    assign err     = q.err;

    // R2
    stop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && q.state == ST_STOP) |=> (q.tx_bit && q.state == ST_IDLE));

    // R9
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> (q.state == ST_STOP));

    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !len_wr) |=> q.done);

    // R10
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && q.state == ST_IDLE && fifo_empty) |=> q.tx_bit);
endmodule

// File: rtl/dchan_tdm_tx.sv
module dchan_tdm_tx #(
    parameter int W        = 8,
    parameter int DEPTH    = 32,
    parameter int MAX_BITS = 8,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          len_wr,
    input  logic [CW-1:0] len_val,
    input  logic          mode_fifo,
    input  logic          unframed,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic [1:0]    rate_sel,
    input  logic [CW-1:0] irq_thresh,
    input  logic          frame_sync,
    input  logic          ts_en,
    output logic          tx_bit,
    output logic          tx_slot,
    output logic          irq,
    output logic          underrun
);
    logic          step, pop, empty, done;
    logic [W-1:0]  head;
    logic [CW-1:0] count;

    dtx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(pop), .head(head), .count(count), .empty(empty)
    );

    dtx_slot_gate #(.MAX_BITS(MAX_BITS)) u_gate (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ts_en(ts_en),
        .rate_sel(rate_sel), .step(step)
    );

    dtx_framer #(.W(W), .LW(CW)) u_framer (
        .clk(clk), .rst_n(rst_n), .step(step), .mode_fifo(mode_fifo),
        .unframed(unframed), .par_en(par_en), .par_odd(par_odd),
        .len_wr(len_wr), .len_val(len_val), .fifo_empty(empty), .head(head),
        .pop(pop), .tx_bit(tx_bit), .tx_slot(tx_slot), .done(done), .err(underrun)
    );

    assign irq = mode_fifo ? (count <= irq_thresh) : done;
endmodule

// File: tb/test_dchan_tdm_tx.sv
module test_dchan_tdm_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       len_wr = 1'b0;
    logic [5:0] len_val = '0;
    logic       mode_fifo = 1'b0, unframed = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic [1:0] rate_sel = 2'd2;
    logic [5:0] irq_thresh = 6'd8;
    logic       frame_sync = 1'b0, ts_en = 1'b0;
    logic       tx_bit, tx_slot, irq, underrun;

    int  n_chk = 0, n_bad = 0;
    bit  cap [0:2047];
    int  ncap = 0;
    bit  exp_b [0:2047];
    int  nexp = 0;

    always #2.5 clk = ~clk;

    dchan_tdm_tx i_dchan_tdm_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .len_wr(len_wr), .len_val(len_val), .mode_fifo(mode_fifo),
        .unframed(unframed), .par_en(par_en), .par_odd(par_odd),
        .rate_sel(rate_sel), .irq_thresh(irq_thresh), .frame_sync(frame_sync),
        .ts_en(ts_en), .tx_bit(tx_bit), .tx_slot(tx_slot), .irq(irq),
        .underrun(underrun)
    );

    always @(negedge clk) begin
        if (tx_slot && ncap < 2048) begin
            cap[ncap] = tx_bit;
            ncap = ncap + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic write_len(input int n);
        @(negedge clk); len_wr = 1'b1; len_val = 6'(n);
        @(negedge clk); len_wr = 1'b0;
    endtask

    // one TDM frame: sync cycle, 8 timeslot bit positions, 2 quiet cycles
    task automatic run_frame();
        @(negedge clk); frame_sync = 1'b1;
        @(negedge clk); frame_sync = 1'b0; ts_en = 1'b1;
        repeat (8) @(negedge clk);
        ts_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic exp_bit(input bit b);
        exp_b[nexp] = b; nexp++;
    endtask

    task automatic exp_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) exp_bit(b[i]);
    endtask

    // compare captured stream from base against expected, rest of window must be idle 1
    task automatic cmp_stream(input int base, input int total, input string tag);
        int bad_i = -1;
        for (int i = 0; i < total; i++) begin
            bit e = (i < nexp) ? exp_b[i] : 1'b1;
            if (bad_i < 0 && cap[base + i] != e) bad_i = i;
        end
        check(bad_i < 0, tag, (bad_i < 0) ? 0 : int'(cap[base + bad_i]),
              (bad_i < 0) ? 0 : ((bad_i < nexp) ? int'(exp_b[bad_i]) : 1));
        if (bad_i >= 0) $display("  first mismatch at bit %0d", bad_i);
        check(ncap - base == total, {tag, " bit count"}, ncap - base, total);
    endtask

    task automatic t_reset();
        check(tx_bit == 1'b1, "R10 reset tx_bit", tx_bit, 1);
        check(tx_slot == 1'b0, "R10 reset tx_slot", tx_slot, 0);
        check(irq == 1'b0, "R3 reset irq", irq, 0);
        check(underrun == 1'b0, "R9 reset underrun", underrun, 0);
    endtask

    task automatic t_msg_even();
        int base;
        mode_fifo = 0; unframed = 0; par_en = 1; par_odd = 0; rate_sel = 2'd2;
        write_byte(8'hA5); write_byte(8'h3C); write_len(2);
        check(irq == 1'b0, "R3 irq low after length write", irq, 0);
        nexp = 0; exp_bit(0); exp_byte(8'hA5); exp_byte(8'h3C);
        exp_bit(^{8'hA5, 8'h3C}); exp_bit(1);
        base = ncap;
        repeat (5) run_frame();
        cmp_stream(base, 40, "R2 R8 message even parity");
        check(irq == 1'b1, "R3 irq after message", irq, 1);
        check(underrun == 1'b0, "R9 no underrun", underrun, 0);
        run_frame();
        check(irq == 1'b1, "R3 irq held", irq, 1);
    endtask

    task automatic t_msg_nopar_odd();
        int base;
        par_en = 0;
        write_byte(8'h81); write_len(1);
        nexp = 0; exp_bit(0); exp_byte(8'h81); exp_bit(1);
        base = ncap;
        repeat (2) run_frame();
        cmp_stream(base, 16, "R2 message without parity");
        par_en = 1; par_odd = 1;
        write_byte(8'h07); write_len(1);
        nexp = 0; exp_bit(0); exp_byte(8'h07); exp_bit(1'b0); exp_bit(1);
        base = ncap;
        repeat (2) run_frame();
        cmp_stream(base, 16, "R8 message odd parity");
    endtask

    task automatic t_fifo_framed();
        int base;
        mode_fifo = 1; unframed = 0; par_en = 1; par_odd = 1; irq_thresh = 6'd8;
        write_byte(8'h12); write_byte(8'hF0);
        nexp = 0;
        exp_bit(0); exp_byte(8'h12); exp_bit(~(^8'h12)); exp_bit(1);
        exp_bit(0); exp_byte(8'hF0); exp_bit(~(^8'hF0)); exp_bit(1);
        base = ncap;
        repeat (3) run_frame();
        cmp_stream(base, 24, "R4 R8 per-byte framing");
    endtask

    task automatic t_unframed();
        int base;
        mode_fifo = 1; unframed = 1;
        write_byte(8'h5A); write_byte(8'hC3);
        nexp = 0; exp_byte(8'h5A); exp_byte(8'hC3);
        base = ncap;
        repeat (3) run_frame();
        cmp_stream(base, 24, "R6 unframed stream");
        unframed = 0;
    endtask

    task automatic t_rate();
        int base, prev;
        bit cnt_ok;
        mode_fifo = 0; par_en = 0;
        for (int r = 0; r < 2; r++) begin
            rate_sel = 2'(r);
            write_byte(8'h96); write_len(1);
            nexp = 0; exp_bit(0); exp_byte(8'h96); exp_bit(1);
            base = ncap;
            cnt_ok = 1;
            for (int f = 0; f < (r == 0 ? 12 : 6); f++) begin
                prev = ncap;
                run_frame();
                if (ncap - prev != r + 1) cnt_ok = 0;
            end
            check(cnt_ok, "R7 bits per frame", cnt_ok, 1);
            cmp_stream(base, 12, "R7 stream at reduced rate");
        end
        rate_sel = 2'd2;
    endtask

    task automatic t_level_irq();
        mode_fifo = 1; unframed = 0; par_en = 0; irq_thresh = 6'd8;
        @(negedge clk);
        check(irq == 1'b1, "R5 irq when empty", irq, 1);
        for (int i = 0; i < 9; i++) write_byte(8'(i + 1));
        check(irq == 1'b0, "R5 irq low at 9 bytes", irq, 0);
        run_frame();
        check(irq == 1'b1, "R5 irq at 8 bytes", irq, 1);
        write_byte(8'h44);
        check(irq == 1'b0, "R5 irq clears on refill", irq, 0);
        repeat (14) run_frame();
        check(irq == 1'b1, "R5 irq after drain", irq, 1);
    endtask

    task automatic t_underrun();
        int base;
        mode_fifo = 0; par_en = 1; par_odd = 0;
        write_byte(8'h5A); write_len(3);
        nexp = 0; exp_bit(0); exp_byte(8'h5A); exp_bit(1);
        base = ncap;
        repeat (3) run_frame();
        cmp_stream(base, 24, "R9 forced stop on underrun");
        check(underrun == 1'b1, "R9 underrun flag", underrun, 1);
        check(irq == 1'b0, "R9 R3 no irq on underrun", irq, 0);
        write_len(1);
        check(underrun == 1'b0, "R9 cleared by length write", underrun, 0);
    endtask

    task automatic t_full();
        int base;
        mode_fifo = 1; unframed = 1;
        nexp = 0;
        for (int i = 0; i < 32; i++) begin
            write_byte(8'(i * 7 + 1));
            exp_byte(8'(i * 7 + 1));
        end
        write_byte(8'h00);
        base = ncap;
        repeat (34) run_frame();
        cmp_stream(base, 272, "R1 overflow byte dropped");
        unframed = 0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_msg_even();
        t_msg_nopar_odd();
        t_fifo_framed();
        t_unframed();
        t_rate();
        t_level_irq();
        t_underrun();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule